// File: doc/BRIEF.md
# Twiddle Angle Generator for a Radix-2² Delay-Feedback FFT Stage

This block supplies one rotation angle per accepted sample to the CORDIC rotator of a radix-2² single-path delay-feedback FFT stage of size N = 2^LOG2N. It reads the stage's sample counter and derives every angle from a simple arithmetic rule, with no angle table and no addressing logic.

The frame is cut into four quarters by the two most significant counter bits. The upper bit is k1 and the next bit is k2. The remaining bits form the in-quarter index n3. The angle for a sample is n3·(k1 + 2·k2)·2π/N. So the quarters use steps of 0, 4π/N, 2π/N and 6π/N, in the order the counter visits them.

Angles use a binary angle format: a full turn is 2^AW, and one step unit (2π/N) is exactly 2^(AW−LOG2N). Because the steps are exact in this format, repeated accumulation does not drift. The parameter ACCUM selects the arithmetic:
- ACCUM=1 (default): an accumulator adds the quarter's step on every accepted sample.
- ACCUM=0: a shift-add product n3·(k1 + 2·k2) is formed directly.

The angle is registered and appears one cycle after the counter value it belongs to, which is the same latency as the data path's single pipeline register.

Top module: `twiddle_angle_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, ang and ang_vld are 0.
- R2: ang_vld equals run delayed by one clock. The angle for the counter value accepted at one clock edge is on ang after that edge.
- R3: When cnt[LOG2N-1:LOG2N-2] = 2'b00 (k1=0, k2=0), the produced angle is 0.
- R4: When cnt[LOG2N-1:LOG2N-2] = 2'b01 (k1=0, k2=1), the angle is n3·2·2^(AW−LOG2N), i.e. n3·4π/N. Here n3 = cnt[LOG2N-3:0].
- R5: When cnt[LOG2N-1:LOG2N-2] = 2'b10 (k1=1, k2=0), the angle is n3·2^(AW−LOG2N), i.e. n3·2π/N.
- R6: When cnt[LOG2N-1:LOG2N-2] = 2'b11 (k1=1, k2=1), the angle is n3·3·2^(AW−LOG2N), i.e. n3·6π/N.
- R7: Any sample with n3 = 0 yields angle 0.
- R8: While run is low, cnt is ignored, ang keeps its value and ang_vld is 0. The next accepted sample continues the quarter as if there had been no gap.
- R9: With ACCUM=1, an accepted sample whose top two counter bits differ from those of the previous accepted sample restarts the accumulator at 0. Later samples of that quarter add its step to that value.
- R10: Every angle is a whole multiple of 2^(AW−LOG2N) and stays below three quarters of a turn (top two bits of ang never 2'b11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Sample accepted this cycle |
| cnt | input | LOG2N | Stage sample counter; top two bits pick the quarter, the rest is n3 |
| ang_vld | output | 1 | Angle on ang is valid |
| ang | output | AW | Rotation angle, full turn = 2^AW |

## Verification
The hardest condition to reach is a quarter change at an n3 that is not zero. A normal counter never produces it, so the R9 restart and the full-frame accumulation cannot be told apart by a plain counting stream. The bench therefore first drives a whole frame, and then a frame with run gaps, to show that accumulation and holding are exact. After that it drives the counter directly: it jumps into the middle of another quarter and then steps within it. The angle must be 0 at the jump and one step per sample afterwards.

// File: rtl/twiddle_angle_gen.sv
module twiddle_angle_gen #(
  parameter int LOG2N = 10,
  parameter int AW    = 16,
  parameter bit ACCUM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LOG2N-1:0] cnt,
  output logic             ang_vld,
  output logic [AW-1:0]    ang
);
  localparam int NB = LOG2N - 2;
  localparam int SH = AW - LOG2N;

  logic          k1, k2;
  logic [1:0]    mult;
  logic [NB-1:0] n3;
  logic [AW-1:0] ang_q, ang_nxt;
  logic          vld_q;

  assign k1   = cnt[LOG2N-1];
  assign k2   = cnt[LOG2N-2];
  assign mult = {k2, k1};
  assign n3   = cnt[NB-1:0];

  generate
    if (ACCUM) begin : g_acc
      logic [AW-1:0] step;
      logic [1:0]    seg_q;
      logic          seen_q;
      assign step = {{(AW-2){1'b0}}, mult} << SH;
      assign ang_nxt = (n3 == '0 || !seen_q || mult != seg_q) ? '0 : ang_q + step;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seg_q  <= 2'b00;
          seen_q <= 1'b0;
        end else if (run) begin
          seg_q  <= mult;
          seen_q <= 1'b1;
        end
      end
    end else begin : g_mul
      logic [NB+1:0] prod;
      assign prod = ({2'b00, n3} & {(NB+2){k1}}) + ({1'b0, n3, 1'b0} & {(NB+2){k2}});
      assign ang_nxt = {{(AW-NB-2){1'b0}}, prod} << SH;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ang_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= run;
      if (run) ang_q <= ang_nxt;
    end
  end

  assign ang     = ang_q;
  assign ang_vld = vld_q;
endmodule

module twiddle_angle_gen_chk #(
  parameter int LOG2N = 10,
  parameter int AW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [LOG2N-1:0] cnt,
  input logic             ang_vld,
  input logic [AW-1:0]    ang
);
  localparam int SH = AW - LOG2N;
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << SH) - AW'(1);

  logic up_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;

  // R2
  vld_follows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (ang_vld == $past(run)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(run)) |-> $stable(ang));

  // R3
  zero_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(run) && $past(cnt[LOG2N-1:LOG2N-2]) == 2'b00) |-> (ang == '0));

  // R7
  n3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(run) && $past(cnt[LOG2N-3:0]) == '0) |-> (ang == '0));

  // R10
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ang[AW-1:AW-2] != 2'b11) && ((ang & LOW_MASK) == '0));
endmodule

bind twiddle_angle_gen twiddle_angle_gen_chk #(.LOG2N(LOG2N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .ang_vld(ang_vld), .ang(ang));

// File: tb/tb_twiddle_angle_gen.sv
module tb_twiddle_angle_gen;
  localparam int LOG2N = 10;
  localparam int AW    = 16;
  localparam int N     = 1 << LOG2N;
  localparam int Q     = N / 4;
  localparam int SH    = AW - LOG2N;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [LOG2N-1:0] cnt = '0;
  logic             ang_vld;
  logic [AW-1:0]    ang;
  int               errors = 0;
  int               checks = 0;

  always #4 clk = ~clk;

  twiddle_angle_gen #(.LOG2N(LOG2N), .AW(AW), .ACCUM(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .ang_vld(ang_vld), .ang(ang));

  function automatic logic [AW-1:0] ref_ang(input logic [LOG2N-1:0] c);
    int m, n;
    m = int'(c[LOG2N-1]) + 2 * int'(c[LOG2N-2]);
    n = int'(c[LOG2N-3:0]);
    return AW'((n * m) << SH);
  endfunction

  function automatic string req_of(input logic [LOG2N-1:0] c);
    if (c[LOG2N-3:0] == '0) return "R7";
    case (c[LOG2N-1:LOG2N-2])
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] a, input logic [AW-1:0] e,
                       input logic v, input logic ev);
    checks++;
    if (a !== e || v !== ev) begin
      errors++;
      $display("FAIL %s: ang=%0d vld=%0b expected ang=%0d vld=%0b", req, a, v, e, ev);
    end
  endtask

  // apply one cycle of inputs at negedge, sample one ns after the next posedge
  task automatic cycle(input logic r, input logic [LOG2N-1:0] c);
    @(negedge clk);
    run = r;
    cnt = c;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1;
    check("R1", ang, '0, ang_vld, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", ang, '0, ang_vld, 1'b0);
  endtask

  task automatic t_full_frame;
    for (int i = 0; i < N; i++) begin
      cycle(1'b1, LOG2N'(i));
      check(req_of(LOG2N'(i)), ang, ref_ang(LOG2N'(i)), ang_vld, 1'b1);
    end
    cycle(1'b0, '0);
    check("R2", ang, ref_ang(LOG2N'(N - 1)), ang_vld, 1'b0);
  endtask

  task automatic t_gapped_frame;
    logic [AW-1:0] last;
    last = ref_ang(LOG2N'(N - 1));
    for (int i = 0; i < N; i++) begin
      if (i % 5 == 2) begin
        cycle(1'b0, LOG2N'((i * 37) % N));
        check("R8", ang, last, ang_vld, 1'b0);
      end
      cycle(1'b1, LOG2N'(i));
      last = ref_ang(LOG2N'(i));
      check(req_of(LOG2N'(i)), ang, last, ang_vld, 1'b1);
    end
  endtask

  task automatic t_jump;
    cycle(1'b1, {2'b01, 8'd20});
    cycle(1'b1, {2'b10, 8'd7});
    check("R9", ang, '0, ang_vld, 1'b1);
    cycle(1'b1, {2'b10, 8'd8});
    check("R9", ang, AW'(1 << SH), ang_vld, 1'b1);
    cycle(1'b1, {2'b10, 8'd9});
    check("R9", ang, AW'(2 << SH), ang_vld, 1'b1);
    cycle(1'b1, {2'b11, 8'd3});
    check("R9", ang, '0, ang_vld, 1'b1);
    cycle(1'b1, {2'b11, 8'd4});
    check("R9", ang, AW'(3 << SH), ang_vld, 1'b1);
    cycle(1'b1, {2'b11, 8'd255});
    check("R10", ang, AW'(6 << SH), ang_vld, 1'b1);
    checks++;
    if (ang[AW-1:AW-2] == 2'b11) begin
      errors++;
      $display("FAIL R10: ang=%0d expected below %0d", ang, 3 << (AW - 2));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_full_frame();
    t_gapped_frame();
    t_jump();
    cycle(1'b0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule